// File: doc/BRIEF.md
# Counter-DAC Threshold Capture

This block turns an analog threshold level into a digital code and then holds that code. A sequencer sends a start pulse. The block then clears a counter and drives the counter value onto an external DAC. On each timebase tick the block reads an external comparator, which reports whether the DAC output has reached the sensed voltage. While the comparator stays low, the counter moves up by one. On the first tick at which the comparator is high, the code is frozen into a hold register and the done flag is raised.

Conversion time depends on the level being sampled: a higher threshold needs more ticks. The result sits in flip-flops, so it does not decay for as long as power-on reset stays released. If the comparator never trips, the counter stops at full scale and the block still finishes. The code width and the number of clock cycles per tick are parameters.

The block has no streaming data path. Every pin is a plain level or pulse with no valid/ready back-pressure, and the held code is valid whenever the done flag is high.

Top module: `level_capture`

## Requirements
- R1: While `rst_n` is low and after its release, `hold_code_o`, `dac_code_o`, `done_o` and `busy_o` are all zero.
- R2: A `start_i` pulse seen at a clock edge while the block is idle and not done sets `busy_o` and leaves `dac_code_o` at 0 after that edge. With no start pulse, the comparator input has no effect and the block stays idle.
- R3: While busy, a tick occurs every `TICK_DIV` clock cycles, the first one `TICK_DIV` edges after the start edge. `dac_code_o` changes only at a tick, and only by +1.
- R4: Capture ends at the first tick where `cmp_hi_i` is high. At that edge `hold_code_o` takes the current `dac_code_o`, `done_o` rises and `busy_o` falls. For a comparator that trips when the DAC code is at or above target T, the held code equals T.
- R5: For a target T no greater than full scale, `done_o` rises exactly (T+1)*`TICK_DIV` clock edges after the start edge.
- R6: If the comparator has not tripped by the tick at which the counter is at full scale (2^`CODE_W`-1), the counter stays at full scale, `hold_code_o` becomes full scale, and `done_o` rises 2^`CODE_W`*`TICK_DIV` edges after the start edge.
- R7: Once `done_o` is high, it stays high and `hold_code_o` and `dac_code_o` stay constant until reset, whatever `cmp_hi_i` does.
- R8: A `start_i` pulse while `busy_o` or `done_o` is high is ignored. It does not restart the counter, does not change the capture time and does not change the held code.
- R9: `busy_o` and `done_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_i | input | 1 | Start pulse from the sequencer |
| cmp_hi_i | input | 1 | Comparator output, high when the DAC output is at or above the sensed level |
| dac_code_o | output | CODE_W | Live counter value that drives the external DAC |
| hold_code_o | output | CODE_W | Captured threshold code, valid while done_o is high |
| done_o | output | 1 | Capture finished; stays high until reset |
| busy_o | output | 1 | Capture in progress |

## Verification
The bench aims at the capture boundaries: target 0, a mid-scale target, exactly full scale, and a level above full scale that never trips. An off-by-one in the tick count or the compare would show up as a held code or a finish cycle that is off by one step, and a counter without saturation would wrap to zero. After completion the bench swings the comparator and pulses start again. A design that does not lock its state would drift or restart. A start pulse in the middle of a capture is also applied, and a design that honours it would come back with a longer capture time.

// File: rtl/lvl_cap_pkg.sv
package lvl_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HELD = 2'd2
  } cap_state_e;
endpackage

// File: rtl/lvl_cap_tick_gen.sv
// Timebase divider: one tick every TICK_DIV cycles while run is high.
module lvl_cap_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign tick = run;
    end else begin : g_divided
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else if (!run || div_q == LAST) begin
          div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end

      assign tick = run && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/lvl_cap_step_counter.sv
// Up counter that drives the DAC; saturates at full scale.
module lvl_cap_step_counter #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [CODE_W-1:0] code,
  output logic              at_max
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  assign at_max = (code == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (clear) begin
      code <= '0;
    end else if (step && !at_max) begin
      code <= code + 1'b1;
    end
  end
endmodule

// File: rtl/lvl_cap_seq_ctrl.sv
// Capture sequencing: idle -> run -> held (held is terminal until reset).
module lvl_cap_seq_ctrl
  import lvl_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic cmp_hi,
  input  logic at_max,
  output logic clear,
  output logic step,
  output logic latch,
  output logic busy,
  output logic done
);
  cap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    clear   = 1'b0;
    step    = 1'b0;
    latch   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          clear   = 1'b1;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (cmp_hi || at_max) begin
            state_d = ST_HELD;
            latch   = 1'b1;
          end else begin
            step = 1'b1;
          end
        end
      end
      ST_HELD: state_d = ST_HELD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == ST_RUN);
  assign done = (state_q == ST_HELD);
endmodule

// File: rtl/level_capture.sv
// Counter-DAC threshold capture top level.
module level_capture #(
  parameter int CODE_W   = 6,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_hi_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [CODE_W-1:0] hold_code_o,
  output logic              done_o,
  output logic              busy_o
);
  logic tick, clear, step, latch, at_max, busy, done;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] hold_q;

  lvl_cap_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  lvl_cap_step_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (step),
    .code  (code),
    .at_max(at_max)
  );

  lvl_cap_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .tick  (tick),
    .cmp_hi(cmp_hi_i),
    .at_max(at_max),
    .clear (clear),
    .step  (step),
    .latch (latch),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (latch) hold_q <= code;
  end

  assign dac_code_o  = code;
  assign hold_code_o = hold_q;
  assign done_o      = done;
  assign busy_o      = busy;
endmodule

// File: rtl/level_capture_chk.sv
module level_capture_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [CODE_W-1:0] hold_code_o,
  input logic              done_o,
  input logic              busy_o
);
  // R2: a start in idle arms the capture from code zero
  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && start_i) |=> (busy_o && dac_code_o == '0));

  // R3: the DAC code only holds or moves up by one while busy
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (dac_code_o == $past(dac_code_o)) ||
               (dac_code_o == CODE_W'($past(dac_code_o) + 1)));

  // R4: the held code equals the counter value when done rises
  a_r4_latch_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (hold_code_o == dac_code_o));

  // R7: once done, everything stays frozen
  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(hold_code_o) && $stable(dac_code_o)));

  // R8: start during a capture does not drop back to idle
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R9: busy and done are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
endmodule

bind level_capture level_capture_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .dac_code_o (dac_code_o),
  .hold_code_o(hold_code_o),
  .done_o     (done_o),
  .busy_o     (busy_o)
);

// File: tb/level_capture_test.sv
`timescale 1ns/1ps
module level_capture_test;
  localparam int CODE_W   = 6;
  localparam int TICK_DIV = 4;
  localparam int MAXC     = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_hi;
  logic [CODE_W-1:0] dac_code, hold_code;
  logic done, busy;
  int target = 0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign cmp_hi = (int'(dac_code) >= target);

  level_capture #(.CODE_W(CODE_W), .TICK_DIV(TICK_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_hi_i(cmp_hi),
    .dac_code_o(dac_code), .hold_code_o(hold_code), .done_o(done), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R1: outputs zero after reset
  task automatic t_reset_state();
    do_reset();
    check(hold_code == 0, "R1 hold", hold_code, 0);
    check(dac_code == 0, "R1 dac", dac_code, 0);
    check(done == 0 && busy == 0, "R1 flags", {done, busy}, 0);
  endtask

  // R2: comparator high while idle does nothing
  task automatic t_idle_ignore();
    do_reset();
    target = 0;
    repeat (40) @(negedge clk);
    check(done == 0 && busy == 0, "R2 idle no capture", {done, busy}, 0);
    check(dac_code == 0, "R2 idle dac", dac_code, 0);
  endtask

  // One capture with per-cycle tracking; optional start pulse mid-run (R8)
  task automatic t_capture(input int tgt, input bit mid_start, input string tag);
    int eff;
    int done_k;
    int k;
    bit trace_ok;
    int bad_act;
    int bad_exp;
    do_reset();
    target = tgt;
    eff = (tgt < MAXC) ? tgt : MAXC;
    done_k = (eff + 1) * TICK_DIV;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1 && dac_code == 0, {"R2 armed ", tag}, {busy, dac_code}, 2**CODE_W);
    k = 0;
    trace_ok = 1'b1;
    bad_act = 0;
    bad_exp = 0;
    while (!done && k < (MAXC + 4) * TICK_DIV) begin
      if (mid_start && k == 5) start = 1'b1;
      if (mid_start && k == 6) start = 1'b0;
      @(negedge clk);
      k++;
      if (!done) begin
        int e;
        e = k / TICK_DIV;
        if (e > eff) e = eff;
        if (int'(dac_code) != e && trace_ok) begin
          trace_ok = 1'b0;
          bad_act = dac_code;
          bad_exp = e;
        end
      end
      if (busy && done) begin
        trace_ok = 1'b0;
        bad_act = 3;
        bad_exp = 1;
      end
    end
    start = 1'b0;
    check(trace_ok, {"R3/R9 step trace ", tag}, bad_act, bad_exp);
    check(int'(hold_code) == eff, {(tgt > MAXC) ? "R6 saturated code " : "R4 held code ", tag},
          hold_code, eff);
    check(k == done_k, {(tgt >= MAXC) ? "R6 full-scale time " : "R5 capture time ", tag},
          k, done_k);
    check(busy == 0, {"R4 busy cleared ", tag}, busy, 0);
  endtask

  // R7/R8: after done, comparator swings and a new start change nothing
  task automatic t_hold_after_done();
    int held;
    bit ok;
    t_capture(37, 1'b0, "pre-hold");
    held = hold_code;
    ok = 1'b1;
    for (int i = 0; i < 120; i++) begin
      target = (i % 2 == 0) ? 0 : 1000;
      @(negedge clk);
      if (int'(hold_code) != held || int'(dac_code) != held || !done || busy) ok = 1'b0;
    end
    check(ok, "R7 frozen after done", hold_code, held);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 1, "R8 start after done ignored", {busy, done}, 1);
    check(int'(hold_code) == held, "R8 held code kept", hold_code, held);
    rst_n = 1'b0;
    @(negedge clk);
    check(hold_code == 0 && done == 0, "R1 reset clears held", hold_code, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset_state();
    t_idle_ignore();
    t_capture(0, 1'b0, "zero");
    t_capture(1, 1'b0, "one");
    t_capture(20, 1'b0, "mid");
    t_capture(20, 1'b1, "mid restart R8");
    t_capture(MAXC, 1'b0, "full");
    t_capture(MAXC + 40, 1'b0, "never trips");
    t_hold_after_done();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule